// File: doc/BRIEF.md
# End-of-Write Status Read Logic

This block sits on the read path of a byte-wide nonvolatile memory. While an internal program or erase cycle runs, it replaces the normal read data with status encodings. These let a host poll for completion without a ready pin. Bit 7 carries the inverted value of the last loaded byte. Bit 6 changes value on every read.

The block receives several inputs: the busy flag from the write timer, a flag giving the cycle type (program or erase), a strobe with the byte being loaded, and the array read data. Each read access starts on a qualified falling edge of the output-enable. At that edge the block latches one data byte and holds it on `rd_data` for the rest of the access. `drive_en` tells the pad logic when to drive the bus.

When the cycle finishes, a short settle window follows. In that window bits 7 and 6 are already valid, and bits 5..0 show a fixed marker pattern. After the window, reads return plain array data.

The controller has four states:
- `ST_IDLE`: normal reads.
- `ST_WR_BUSY`: program cycle running.
- `ST_ER_BUSY`: erase cycle running.
- `ST_SETTLE`: completion window.

Its transitions are:
- `ST_IDLE` to `ST_WR_BUSY`: on busy with the erase flag low.
- `ST_IDLE` to `ST_ER_BUSY`: on busy with the erase flag high.
- Either busy state to `ST_SETTLE`: when busy drops.
- `ST_SETTLE` back to one of the busy states: when busy rises again (restart).
- `ST_SETTLE` to `ST_IDLE`: when the window counter expires.

Top module: `eow_status_read`

## Requirements
- R1: After reset `rd_data` is 0x00 and `drive_en` is 0, and a read returns plain array data.
- R2: `drive_en` is 1 exactly while `ce_n` and `oe_n` are both 0.
- R3: A read is a falling edge of `oe_n` while `ce_n` is 0. It latches one byte into `rd_data`, visible after the next rising clock, and the byte is held until the next read. In idle the latched byte equals `arr_data`.
- R4: A pulse on `ld_stb` stores `ld_data` as the last loaded byte. A later pulse replaces it.
- R5: During a program cycle, bit 7 of a read is the complement of bit 7 of the last loaded byte, and bits 5..0 equal `arr_data[5:0]`.
- R6: During any busy cycle, bit 6 is 1 on the first read of the cycle and alternates on each following read.
- R7: During an erase cycle, bit 7 of a read is 0 and bit 6 follows R6.
- R8: An `oe_n` falling edge while `ce_n` is 1 neither changes `rd_data` nor advances the bit-6 sequence.
- R9: For SETTLE_CYC cycles after busy falls, a read returns `arr_data[7:6]` in bits 7..6 and the SETTLE_PAT value (default 6'b101010) in bits 5..0.
- R10: After the settle window, reads return `arr_data` unchanged, and bit 6 no longer alternates.
- R11: Busy rising again during the settle window starts a new cycle, and its first read gives bit 6 = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| busy | input | 1 | Internal write or erase cycle in progress |
| erase_cyc | input | 1 | Cycle type at busy start: 1 = erase, 0 = program |
| ld_stb | input | 1 | Byte-load strobe |
| ld_data | input | DW | Byte being loaded |
| arr_data | input | DW | Array read data |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| rd_data | output | DW | Latched read data |
| drive_en | output | 1 | Bus drive enable |

## Verification
The hardest situation to reach from the ports is a read that lands inside the short settle window, or a fresh busy edge arriving while that window is still open. Both depend on where the read falls relative to busy dropping, counted to the clock. The stimulus starts a read on the very next falling clock edge after busy drops, and restarts busy in the middle of the window. This places reads inside the window deterministically. Random program and erase cycles, with random read counts, also cover the alternation of bit 6 across cycle boundaries.

// File: rtl/eow_pkg.sv
package eow_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_WR_BUSY = 2'd1,
        ST_ER_BUSY = 2'd2,
        ST_SETTLE  = 2'd3
    } eow_state_t;
endpackage

// File: rtl/eow_seq.sv
module eow_seq
    import eow_pkg::*;
#(
    parameter int SETTLE_CYC = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       busy,
    input  logic       erase_cyc,
    output eow_state_t state,
    output logic       cyc_start
);
    localparam int CW = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;

    eow_state_t      nxt;
    logic [CW-1:0]   cnt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE, ST_SETTLE: begin
                if (busy)
                    nxt = erase_cyc ? ST_ER_BUSY : ST_WR_BUSY;
                else if (state == ST_SETTLE && cnt == '0)
                    nxt = ST_IDLE;
            end
            ST_WR_BUSY, ST_ER_BUSY: begin
                if (!busy) nxt = ST_SETTLE;
            end
        endcase
    end

    assign cyc_start = (state == ST_IDLE || state == ST_SETTLE) && busy;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= nxt;
            if (nxt == ST_SETTLE && state != ST_SETTLE)
                cnt <= CW'(SETTLE_CYC - 1);
            else if (state == ST_SETTLE && cnt != '0)
                cnt <= cnt - 1'b1;
        end
    end

    // R10: window expiry returns to idle
    a_r10_settle_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SETTLE && !busy && cnt == '0) |=> state == ST_IDLE);
    // R11: busy during settle restarts a cycle
    a_r11_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SETTLE && busy) |=> (state == ST_WR_BUSY || state == ST_ER_BUSY));
    // R9: busy falling always enters the window
    a_r9_enter_settle: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_WR_BUSY || state == ST_ER_BUSY) && !busy) |=> state == ST_SETTLE);
endmodule

// File: rtl/eow_toggle.sv
module eow_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic oe_n,
    input  logic in_busy,
    input  logic cyc_start,
    output logic rd_fire,
    output logic tog
);
    logic oe_q;

    assign rd_fire = oe_q && !oe_n && !ce_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe_q <= 1'b1;
            tog  <= 1'b1;
        end else begin
            oe_q <= oe_n;
            if (cyc_start)
                tog <= 1'b1;
            else if (rd_fire && in_busy)
                tog <= ~tog;
        end
    end

    // R6: new cycle starts the sequence at 1
    a_r6_first_one: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_start |=> tog);
    // R6: each busy read flips the bit
    a_r6_flip: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_fire && in_busy && !cyc_start) |=> tog != $past(tog));
    // R8/R10: no read or no busy, no change
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!cyc_start && !(rd_fire && in_busy)) |=> $stable(tog));
endmodule

// File: rtl/eow_rdmux.sv
module eow_rdmux
    import eow_pkg::*;
#(
    parameter int              DW         = 8,
    parameter logic [DW-3:0]   SETTLE_PAT = '0
) (
    input  eow_state_t    state,
    input  logic          tog,
    input  logic [DW-1:0] last_byte,
    input  logic [DW-1:0] arr_data,
    output logic [DW-1:0] status
);
    localparam int LOW = DW - 2;

    always_comb begin
        unique case (state)
            ST_WR_BUSY: status = {~last_byte[DW-1], tog, arr_data[LOW-1:0]};
            ST_ER_BUSY: status = {1'b0, tog, arr_data[LOW-1:0]};
            ST_SETTLE:  status = {arr_data[DW-1:DW-2], SETTLE_PAT};
            default:    status = arr_data;
        endcase
    end
endmodule

// File: rtl/eow_status_read.sv
module eow_status_read
    import eow_pkg::*;
#(
    parameter int            DW         = 8,
    parameter int            SETTLE_CYC = 8,
    parameter logic [DW-3:0] SETTLE_PAT = 6'b101010
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          busy,
    input  logic          erase_cyc,
    input  logic          ld_stb,
    input  logic [DW-1:0] ld_data,
    input  logic [DW-1:0] arr_data,
    input  logic          ce_n,
    input  logic          oe_n,
    output logic [DW-1:0] rd_data,
    output logic          drive_en
);
    eow_state_t    state;
    logic          cyc_start, rd_fire, tog, in_busy;
    logic [DW-1:0] last_q, status, rd_q;

    eow_seq #(.SETTLE_CYC(SETTLE_CYC)) u_seq (
        .clk(clk), .rst_n(rst_n), .busy(busy), .erase_cyc(erase_cyc),
        .state(state), .cyc_start(cyc_start));

    assign in_busy = (state == ST_WR_BUSY) || (state == ST_ER_BUSY);

    eow_toggle u_tog (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n),
        .in_busy(in_busy), .cyc_start(cyc_start), .rd_fire(rd_fire), .tog(tog));

    eow_rdmux #(.DW(DW), .SETTLE_PAT(SETTLE_PAT)) u_mux (
        .state(state), .tog(tog), .last_byte(last_q),
        .arr_data(arr_data), .status(status));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= '0;
            rd_q   <= '0;
        end else begin
            if (ld_stb)  last_q <= ld_data;
            if (rd_fire) rd_q   <= status;
        end
    end

    assign rd_data  = rd_q;
    assign drive_en = !ce_n && !oe_n;

    // R5: program-cycle read inverts last byte bit 7
    a_r5_poll_inv: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_fire && state == ST_WR_BUSY && !ld_stb) |=> rd_data[DW-1] == ~last_q[DW-1]);
    // R7: erase-cycle read gives bit 7 low
    a_r7_erase_b7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_fire && state == ST_ER_BUSY) |=> !rd_data[DW-1]);
    // R3/R8: data held between reads
    a_r8_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_fire |=> $stable(rd_data));
endmodule

// File: tb/eow_status_read_test.sv
module eow_status_read_test;
    localparam int CLK_PERIOD = 10;
    localparam int SETTLE_CYC = 8;
    localparam logic [5:0] PAT = 6'b101010;

    logic clk = 0, rst_n = 0, busy = 0, erase_cyc = 0, ld_stb = 0;
    logic ce_n = 1, oe_n = 1;
    logic [7:0] ld_data = 0, arr_data = 0;
    logic [7:0] rd_data;
    logic drive_en;
    int n_chk = 0, n_fail = 0;
    logic [7:0] last_m;
    logic       tog_m;
    logic [7:0] got;

    eow_status_read #(.DW(8), .SETTLE_CYC(SETTLE_CYC), .SETTLE_PAT(PAT)) uut (
        .clk(clk), .rst_n(rst_n), .busy(busy), .erase_cyc(erase_cyc),
        .ld_stb(ld_stb), .ld_data(ld_data), .arr_data(arr_data),
        .ce_n(ce_n), .oe_n(oe_n), .rd_data(rd_data), .drive_en(drive_en));

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run did not finish (got 0 expected 1)");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    function automatic logic [7:0] exp_busy(input logic er, input logic [7:0] lb,
                                            input logic [7:0] arr, input logic t);
        return {er ? 1'b0 : ~lb[7], t, arr[5:0]};
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic load(input logic [7:0] d);
        @(negedge clk); ld_data = d; ld_stb = 1;
        @(negedge clk); ld_stb = 0;
        last_m = d;
    endtask

    task automatic do_read(output logic [7:0] v);
        @(negedge clk); ce_n = 0; oe_n = 0;
        @(negedge clk); v = rd_data;
        oe_n = 1; ce_n = 1;
        @(negedge clk);
    endtask

    task automatic start_cyc(input logic er);
        @(negedge clk); erase_cyc = er; busy = 1;
        @(negedge clk);
        tog_m = 1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 rd_data", rd_data, 8'h00);
        chk("R1 drive_en", {7'b0, drive_en}, 8'h00);
        rst_n = 1;
        arr_data = 8'h5C;
        do_read(got);
        chk("R1/R3 idle read", got, 8'h5C);

        // R2: drive enable combinations
        @(negedge clk); ce_n = 0; oe_n = 1; #1 chk("R2 ce only", {7'b0, drive_en}, 8'h00);
        ce_n = 1; oe_n = 0; #1 chk("R2 oe only", {7'b0, drive_en}, 8'h00);
        ce_n = 0; oe_n = 0; #1 chk("R2 both", {7'b0, drive_en}, 8'h01);
        @(negedge clk); ce_n = 1; oe_n = 1;

        // R4/R5/R6 directed program cycle
        load(8'h80); load(8'h13);
        arr_data = 8'hF7;
        start_cyc(0);
        do_read(got); chk("R4/R5/R6 first read", got, exp_busy(0, 8'h13, 8'hF7, 1));
        do_read(got); chk("R6 second read", got, exp_busy(0, 8'h13, 8'hF7, 0));
        // R8: oe fall with ce high
        @(negedge clk); oe_n = 0; @(negedge clk);
        chk("R8 no capture", rd_data, exp_busy(0, 8'h13, 8'hF7, 0));
        oe_n = 1; @(negedge clk);
        do_read(got); chk("R8 sequence not advanced", got, exp_busy(0, 8'h13, 8'hF7, 1));

        // R9: read right after busy falls
        @(negedge clk); busy = 0;
        do_read(got); chk("R9 settle pattern", got, {8'hF7 & 8'hC0} | {2'b00, PAT});
        // R11: restart inside window
        @(negedge clk); busy = 1; erase_cyc = 1;
        @(negedge clk);
        do_read(got); chk("R11/R7 restart first read", got, exp_busy(1, 8'h13, 8'hF7, 1));
        do_read(got); chk("R7 erase toggles", got, exp_busy(1, 8'h13, 8'hF7, 0));
        @(negedge clk); busy = 0;
        repeat (SETTLE_CYC + 2) @(negedge clk);
        do_read(got); chk("R10 array after window", got, 8'hF7);
        do_read(got); chk("R10 no toggle", got, 8'hF7);

        // random cycles
        void'($urandom(32'h1A2B));
        for (int c = 0; c < 40; c++) begin
            logic er;
            int nr;
            er = 1'($urandom);
            load(8'($urandom));
            arr_data = 8'($urandom);
            start_cyc(er);
            nr = 1 + int'($urandom % 5);
            for (int r = 0; r < nr; r++) begin
                do_read(got);
                chk(er ? "R7 random erase read" : "R5/R6 random program read",
                    got, exp_busy(er, last_m, arr_data, tog_m));
                tog_m = ~tog_m;
            end
            @(negedge clk); busy = 0;
            repeat (SETTLE_CYC + 2) @(negedge clk);
            do_read(got); chk("R10 random idle read", got, arr_data);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule